// File: doc/BRIEF.md
# Reconfigurable Piecewise-Linear Function Evaluator

This block approximates one of five nonlinear functions of an unsigned fixed-point operand. Each function's domain is split into straight-line segments. A 3-bit function code and an 11-bit operand with 10 fractional bits select one segment. The block then looks up that segment's stored slope and intercept and evaluates `y = floor(x*k) + b`. A single radix-4 Booth multiplier, a carry-save reduction and one final adder serve all five functions. The block has no separate datapath for each function.

The slope is stored already rounded. The product is cut back to ten fractional bits by discarding its low bits, with no rounding. The intercept is then added and the sum is clamped to the output range. The result goes into a register together with a valid flag one cycle after the operand is presented. Because the function code is a plain input, a caller can interleave evaluations of different functions on consecutive cycles.

Top module: `pwl_eval`

## Requirements
- R1: While `rst` is high at a rising edge, `y_out` becomes 0 and `out_valid` becomes 0 after that edge.
- R2: After each rising edge with `rst` low, `out_valid` equals the value `in_valid` had at that edge.
- R3: After a rising edge where `in_valid` is low, `y_out` keeps its previous value.
- R4: Function code f selects n segments: n is 15 for code 0, 14 for codes 1 and 2, and 7 for codes 3 and 4. Its breakpoints are floor(j*j*2048/(n*n)) for j = 1..n-1, in units of 2^-10. The local segment number s is the count of breakpoints less than or equal to x. The table entry used is g = s plus the sum of the segment counts of all lower codes, which gives 57 entries in total.
- R5: Entry g holds an 8-bit two's complement slope k = ((37g+11) mod 156) - 63 in units of 2^-6, and an 11-bit unsigned intercept b = ((211g+5) mod 1126) + 1 in units of 2^-10.
- R6: The value x*k has 16 fractional bits. It is reduced to 10 fractional bits by dropping the low 6 bits of its two's complement form, which equals floor(x*k/64) and also holds for negative products.
- R7: If floor(x*k/64) + b is negative, the registered result is 0.
- R8: If floor(x*k/64) + b exceeds 2047, the registered result is 2047.
- R9: A function code of 5, 6 or 7 presented with `in_valid` high gives a registered result of 0.
- R10: An operand exactly equal to a breakpoint uses the segment above that breakpoint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and function code are valid |
| func_sel | input | 3 | Function code, 0 to 4 valid |
| x_in | input | 11 | Unsigned operand, 10 fractional bits |
| out_valid | output | 1 | Registered result is valid |
| y_out | output | 11 | Result, 1 integer and 10 fractional bits |

## Verification
The hardest cases to reach are operands that sit exactly on a breakpoint or one code below it, where an off-by-one in the comparison sends the lookup to the neighbouring segment. A coarse sweep of the operand can step over these points and miss such an error. The stimulus therefore visits every breakpoint of every function at the breakpoint value and at the value just below it. It also sweeps the whole operand range for each function, which reaches negative products with non-zero discarded bits and both clamp limits. Invalid codes and idle cycles are mixed in between.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int X_W       = 11;
  localparam int X_FRAC    = 10;
  localparam int K_W       = 8;
  localparam int K_FRAC    = 6;
  localparam int B_W       = 11;
  localparam int Y_W       = 11;
  localparam int SEL_W     = 3;
  localparam int NUM_FN    = 5;
  localparam int MAX_SEG   = 15;
  localparam int SEG_TOTAL = 57;
  localparam int SEG_IDX_W = $clog2(SEG_TOTAL);
  localparam int LOCAL_W   = $clog2(MAX_SEG + 1);
  localparam int NDIG      = K_W / 2;
  localparam int PROD_W    = X_W + K_W + 1;
  localparam int SUM_W     = PROD_W + 1;

  // number of segments owned by each function code
  function automatic int seg_count(input int f);
    case (f)
      0:       return 15;
      1, 2:    return 14;
      default: return 7;
    endcase
  endfunction

  // first table entry of function f
  function automatic int seg_base(input int f);
    int s;
    s = 0;
    for (int i = 0; i < f; i++) s += seg_count(i);
    return s;
  endfunction

  // breakpoint j (0-based) of function f, quadratic spacing
  function automatic int brk_at(input int f, input int j);
    int n;
    n = seg_count(f);
    return ((j + 1) * (j + 1) * (1 << X_W)) / (n * n);
  endfunction

  // pre-rounded slope of table entry g, units of 2^-K_FRAC
  function automatic int slope_at(input int g);
    return ((g * 37 + 11) % 156) - 63;
  endfunction

  // pre-rounded intercept of table entry g, units of 2^-X_FRAC
  function automatic int icpt_at(input int g);
    return ((g * 211 + 5) % 1126) + 1;
  endfunction

  // one radix-4 Booth partial product, before its weight shift
  function automatic logic [PROD_W-1:0] booth_pp(input logic [2:0] trip,
                                                 input logic [X_W-1:0] x);
    logic [PROD_W-1:0] m;
    logic neg;
    case (trip)
      3'b001, 3'b010, 3'b101, 3'b110: m = PROD_W'(x);
      3'b011, 3'b100:                 m = PROD_W'(x) << 1;
      default:                        m = '0;
    endcase
    neg = trip[2] & ~(trip[1] & trip[0]);
    return neg ? (~m + 1'b1) : m;
  endfunction
endpackage

// File: rtl/pwl_seg_select.sv
module pwl_seg_select
  import pwl_pkg::*;
(
  input  logic [X_W-1:0]       x,
  input  logic [SEL_W-1:0]     fsel,
  output logic [SEG_IDX_W-1:0] seg_idx,
  output logic                 sel_ok
);
  localparam int NBRK = MAX_SEG - 1;

  logic [NUM_FN-1:0][NBRK-1:0] hit;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    for (genvar j = 0; j < NBRK; j++) begin : g_bp
      if (j < seg_count(f) - 1) begin : g_cmp
        assign hit[f][j] = (x >= X_W'(brk_at(f, j)));
      end else begin : g_none
        assign hit[f][j] = 1'b0;
      end
    end
  end

  logic [NBRK-1:0]      row;
  logic [LOCAL_W-1:0]   local_seg;
  logic [SEG_IDX_W-1:0] base;

  always_comb begin
    row  = '0;
    base = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (fsel == SEL_W'(f)) begin
        row  = hit[f];
        base = SEG_IDX_W'(seg_base(f));
      end
    end
    local_seg = '0;
    for (int j = 0; j < NBRK; j++) local_seg = local_seg + LOCAL_W'(row[j]);
  end

  assign sel_ok  = (fsel < SEL_W'(NUM_FN));
  assign seg_idx = base + SEG_IDX_W'(local_seg);
endmodule

// File: rtl/pwl_coef_rom.sv
module pwl_coef_rom
  import pwl_pkg::*;
(
  input  logic [SEG_IDX_W-1:0]  idx,
  output logic signed [K_W-1:0] kq,
  output logic [B_W-1:0]        bq
);
  logic [K_W-1:0] k_tab [SEG_TOTAL];
  logic [B_W-1:0] b_tab [SEG_TOTAL];

  for (genvar g = 0; g < SEG_TOTAL; g++) begin : g_ent
    assign k_tab[g] = K_W'(slope_at(g));
    assign b_tab[g] = B_W'(icpt_at(g));
  end

  always_comb begin
    if (idx < SEG_IDX_W'(SEG_TOTAL)) begin
      kq = k_tab[idx];
      bq = b_tab[idx];
    end else begin
      kq = '0;
      bq = '0;
    end
  end
endmodule

// File: rtl/pwl_booth_mul.sv
module pwl_booth_mul
  import pwl_pkg::*;
(
  input  logic [X_W-1:0]           x,
  input  logic signed [K_W-1:0]    k,
  output logic signed [PROD_W-1:0] prod
);
  logic [K_W:0]        kx;
  logic [PROD_W-1:0]   pp [NDIG];

  assign kx = {k, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_pp
    assign pp[i] = booth_pp(kx[2*i+2:2*i], x) << (2 * i);
  end

  // carry-save reduction of the partial products, one final adder
  always_comb begin
    logic [PROD_W-1:0] s, c, ns, nc;
    s = pp[0];
    c = '0;
    for (int i = 1; i < NDIG; i++) begin
      ns = s ^ c ^ pp[i];
      nc = ((s & c) | (s & pp[i]) | (c & pp[i])) << 1;
      s  = ns;
      c  = nc;
    end
    prod = s + c;
  end
endmodule

// File: rtl/pwl_trunc_add.sv
module pwl_trunc_add
  import pwl_pkg::*;
(
  input  logic signed [PROD_W-1:0] prod,
  input  logic [B_W-1:0]           b,
  output logic [Y_W-1:0]           y,
  output logic                     sat_lo,
  output logic                     sat_hi
);
  logic signed [PROD_W-1:0] shifted;
  logic [SUM_W-1:0]         sum;

  // dropping the low bits of the two's complement value = floor
  assign shifted = prod >>> K_FRAC;
  assign sum     = {shifted[PROD_W-1], shifted} + SUM_W'(b);
  assign sat_lo  = sum[SUM_W-1];
  assign sat_hi  = ~sat_lo & (|sum[SUM_W-2:Y_W]);
  assign y       = sat_lo ? '0 : (sat_hi ? '1 : sum[Y_W-1:0]);
endmodule

// File: rtl/pwl_eval.sv
module pwl_eval
  import pwl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] func_sel,
  input  logic [X_W-1:0]   x_in,
  output logic             out_valid,
  output logic [Y_W-1:0]   y_out
);
  logic [SEG_IDX_W-1:0]     seg_idx_w;
  logic                     sel_ok_w;
  logic signed [K_W-1:0]    kq_w;
  logic [B_W-1:0]           bq_w;
  logic signed [PROD_W-1:0] prod_w;
  logic [Y_W-1:0]           y_comb_w;
  logic                     sat_lo_w;
  logic                     sat_hi_w;

  pwl_seg_select u_sel (
    .x(x_in), .fsel(func_sel), .seg_idx(seg_idx_w), .sel_ok(sel_ok_w)
  );

  pwl_coef_rom u_rom (
    .idx(seg_idx_w), .kq(kq_w), .bq(bq_w)
  );

  pwl_booth_mul u_mul (
    .x(x_in), .k(kq_w), .prod(prod_w)
  );

  pwl_trunc_add u_add (
    .prod(prod_w), .b(bq_w), .y(y_comb_w), .sat_lo(sat_lo_w), .sat_hi(sat_hi_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) y_out <= sel_ok_w ? y_comb_w : '0;
    end
  end
endmodule

// File: rtl/pwl_eval_chk.sv
module pwl_eval_chk
  import pwl_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [SEL_W-1:0]     func_sel,
  input logic                 out_valid,
  input logic [Y_W-1:0]       y_out,
  input logic                 sat_lo,
  input logic                 sat_hi,
  input logic [SEG_IDX_W-1:0] seg_idx,
  input logic                 sel_ok
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && y_out == '0)); // R1
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(y_out)); // R3
  AST_SEG_BOUND: assert property (@(posedge clk) disable iff (rst) sel_ok |-> seg_idx < SEG_IDX_W'(SEG_TOTAL)); // R4
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst) (in_valid && sel_ok && sat_lo) |=> y_out == '0); // R7
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst) (in_valid && sel_ok && sat_hi) |=> y_out == '1); // R8
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst) (in_valid && func_sel >= SEL_W'(NUM_FN)) |=> y_out == '0); // R9
endmodule

bind pwl_eval pwl_eval_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .func_sel(func_sel),
  .out_valid(out_valid), .y_out(y_out), .sat_lo(sat_lo_w), .sat_hi(sat_hi_w),
  .seg_idx(seg_idx_w), .sel_ok(sel_ok_w)
);

// File: tb/pwl_eval_tb.sv
module pwl_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  func_sel = '0;
  logic [10:0] x_in = '0;
  logic        out_valid;
  logic [10:0] y_out;

  int    n_checks = 0;
  int    n_fail = 0;
  int    exp_y = 0;
  int    exp_v = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  pwl_eval dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func_sel(func_sel),
    .x_in(x_in), .out_valid(out_valid), .y_out(y_out)
  );

  function automatic int nseg(int f);
    if (f == 0) return 15;
    if (f <= 2) return 14;
    return 7;
  endfunction

  // behavioural reference, restated from the requirements
  function automatic int model(int f, int x, output string tag);
    int n, base, s, g, k, b, p, t, sum;
    bit on_bp;
    if (f >= 5) begin tag = "R9"; return 0; end
    n = nseg(f);
    base = 0;
    for (int i = 0; i < f; i++) base += nseg(i);
    s = 0; on_bp = 0;
    for (int j = 1; j < n; j++) begin
      int bp;
      bp = (j * j * 2048) / (n * n);
      if (x >= bp) s++;
      if (x == bp) on_bp = 1;
    end
    g = base + s;
    k = ((g * 37 + 11) % 156) - 63;
    b = ((g * 211 + 5) % 1126) + 1;
    p = x * k;
    t = p >>> 6;
    sum = t + b;
    if (sum < 0) begin tag = "R7"; return 0; end
    if (sum > 2047) begin tag = "R8"; return 2047; end
    if (on_bp) tag = "R10";
    else if (p < 0 && (p & 63) != 0) tag = "R6";
    else tag = "R4,R5";
    return sum;
  endfunction

  task automatic check_now();
    n_checks++;
    if (int'(out_valid) != exp_v) begin
      n_fail++;
      $display("FAIL R2 out_valid actual=%0d expected=%0d", out_valid, exp_v);
    end
    n_checks++;
    if (int'(y_out) != exp_y) begin
      n_fail++;
      $display("FAIL %s y_out actual=%0d expected=%0d", cur_tag, y_out, exp_y);
    end
  endtask

  task automatic drive(bit v, int f, int x);
    string tg;
    int    r;
    @(negedge clk);
    check_now();
    in_valid = v;
    func_sel = 3'(f);
    x_in     = 11'(x);
    exp_v    = v;
    if (v) begin
      r = model(f, x, tg);
      exp_y = r;
      cur_tag = tg;
    end else begin
      cur_tag = "R3";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // first drive checks the reset state (R1)
    for (int f = 0; f < 5; f++) begin
      for (int x = 0; x < 2048; x += 5) drive(1, f, x);
      drive(1, f, 2047);
      drive(0, f, 1234);
      drive(0, 4 - f, 17);
    end
    // every breakpoint and the code below it (R10)
    for (int f = 0; f < 5; f++) begin
      for (int j = 1; j < nseg(f); j++) begin
        int bp;
        bp = (j * j * 2048) / (nseg(f) * nseg(f));
        drive(1, f, bp);
        drive(1, f, bp - 1);
      end
    end
    // out-of-range codes (R9), interleaved with valid ones
    for (int c = 5; c < 8; c++) begin
      drive(1, 0, 700);
      drive(1, c, 700);
      drive(0, 1, 3);
      drive(1, c, 2047);
    end
    // back-to-back function switching
    for (int x = 0; x < 2048; x += 97) drive(1, x % 5, x);
    drive(0, 0, 0);
    @(negedge clk);
    check_now();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule